// File: doc/BRIEF.md
# In-Order Issue Hazard Checker for Mixed-Latency Execution Units

This block sits at the decode stage of an in-order pipeline. The pipeline feeds four execution paths: a single-cycle integer path, a pipelined floating-point adder, a pipelined multiplier and a divider that is not pipelined. Each cycle the decode stage offers at most one instruction, together with its target unit, its destination register and up to two source registers. The block decides whether that instruction may issue in the current cycle. It checks four conditions at the same time and reports each one on its own cause bit:

- a source operand whose result is still in flight;
- a divider that is still occupied;
- a writeback slot that another result has already claimed;
- an older write to the same destination that would finish after the new one.

Internally, every register has a countdown to its pending result. A shifting reservation vector records which future cycles already have a writeback, and the tag of the register written in each of those cycles. The block drives the writeback strobe and the destination tag for each cycle. The arithmetic units live outside the block. The decode stage holds a stalled instruction on the inputs until the block accepts it, so issue stays strictly in program order.

Top module: `hzd_issue_ctrl`

## Requirements
- R1: An integer instruction (unit code 00) that writes a register produces `wb_valid_o` = 1 and `wb_dst_o` = its destination in the cycle after it issues. A dependent instruction offered in that next cycle issues with no stall.
- R2: A consumer of a register written by an adder (code 01), multiplier (code 10) or divider (code 11) instruction stalls for 3, 6 or 24 cycles respectively when offered right after the producer. While it stalls, cause bit 1 is set.
- R3: A source register is checked only when its read flag is high, and a pending result on either source A or source B stalls the instruction.
- R4: A divide offered while an earlier divide is in the divider issues no sooner than 25 cycles after the earlier one. While it waits, cause bit 0 is set.
- R5: An instruction whose writeback cycle is already reserved by an earlier instruction stalls, with cause bit 2 set, until a free slot lines up.
- R6: An instruction that writes the same register as an older in-flight instruction stalls, with cause bit 3 set, until the older result would be written strictly first. If the older result already finishes first, the instruction does not stall.
- R7: An instruction whose write flag is low reserves no writeback and leaves its destination register free for later readers.
- R8: With `in_valid` high, exactly one of `issue_o` and `stall_o` is high. With `in_valid` low, both are low. A held instruction issues in the first cycle in which all four checks clear.
- R9: During and right after reset, no register is pending, no writeback is signalled and no stall is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | An instruction is offered this cycle |
| in_unit | input | 2 | Target unit: 00 integer, 01 adder, 10 multiplier, 11 divider |
| in_wr | input | 1 | Instruction writes a destination register |
| in_dst | input | REG_W | Destination register |
| in_src_a | input | REG_W | First source register |
| in_rd_a | input | 1 | First source is read |
| in_src_b | input | REG_W | Second source register |
| in_rd_b | input | 1 | Second source is read |
| issue_o | output | 1 | Offered instruction issues at this clock edge |
| stall_o | output | 1 | Offered instruction is held |
| stall_why_o | output | 4 | Causes: bit3 write order, bit2 writeback slot, bit1 operand pending, bit0 divider busy |
| wb_valid_o | output | 1 | A result is written back this cycle |
| wb_dst_o | output | REG_W | Register written back this cycle |

## Verification
Some properties are checked on every cycle:

- `issue_o` and `stall_o` are mutually exclusive.
- An integer write always appears on the writeback port one cycle after it issues.
- A reader is never let through in the cycle right after its adder producer.
- A same-register write that trails a multiply is flagged as a write-order hazard.
- Divides are never spaced closer than the initiation interval.

Other behaviour only the directed scenarios can show: the exact stall lengths for each producer latency, the choice between the two sources, a writeback slot collision that clears after one cycle, the no-stall case when the older write finishes first, and non-writing instructions that leave no trace.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

  typedef enum logic [1:0] {
    U_INT = 2'b00,
    U_ADD = 2'b01,
    U_MUL = 2'b10,
    U_DIV = 2'b11
  } unit_e;

  // packed order: first member is the most significant bit
  typedef struct packed {
    logic waw;   // bit 3
    logic port;  // bit 2
    logic raw;   // bit 1
    logic div;   // bit 0
  } why_t;

  function automatic int max_of4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/hzd_reg_timer.sv
// Countdown of cycles until a register's pending result is written back.
module hzd_reg_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (cnt_q != '0)
      cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/hzd_scoreboard.sv
// Per-register pending state: operand and write-order checks.
module hzd_scoreboard #(
  parameter int REG_W = 5,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  logic             wr,
  input  logic [REG_W-1:0] dst,
  input  logic [CNT_W-1:0] lat,
  input  logic [REG_W-1:0] src_a,
  input  logic             rd_a,
  input  logic [REG_W-1:0] src_b,
  input  logic             rd_b,
  output logic             raw_o,
  output logic             waw_o
);

  localparam int NREG = 1 << REG_W;

  logic [CNT_W-1:0] remain [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic hit;
    assign hit = issue && wr && (dst == REG_W'(g));
    hzd_reg_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (hit),
      .load_val (lat),
      .cnt_o    (remain[g])
    );
  end

  // a count of 1 means the result is written this cycle and can be forwarded
  logic raw_a, raw_b;
  assign raw_a = rd_a && (remain[src_a] > CNT_W'(1));
  assign raw_b = rd_b && (remain[src_b] > CNT_W'(1));
  assign raw_o = raw_a || raw_b;

  // older write lands in cycle now+remain-1, new one in now+lat
  assign waw_o = wr && (remain[dst] > lat);

endmodule

// File: rtl/hzd_wb_slots.sv
// Shift-register reservation of the single writeback port.
module hzd_wb_slots #(
  parameter int REG_W = 5,
  parameter int CNT_W = 5,
  parameter int DEPTH = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  logic             wr,
  input  logic [REG_W-1:0] dst,
  input  logic [CNT_W-1:0] lat,
  output logic             clash_o,
  output logic             wb_valid_o,
  output logic [REG_W-1:0] wb_dst_o
);

  // slot j: a writeback happens j cycles from now
  logic [DEPTH:0]   resv_q, resv_d;
  logic [REG_W-1:0] tag_q [DEPTH+1];
  logic [REG_W-1:0] tag_d [DEPTH+1];

  always_comb begin
    for (int j = 0; j < DEPTH; j++) begin
      resv_d[j] = resv_q[j+1];
      tag_d[j]  = tag_q[j+1];
      if (issue && wr && (int'(lat) == j + 1)) begin
        resv_d[j] = 1'b1;
        tag_d[j]  = dst;
      end
    end
    resv_d[DEPTH] = 1'b0;
    tag_d[DEPTH]  = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resv_q <= '0;
      for (int j = 0; j <= DEPTH; j++) tag_q[j] <= '0;
    end else begin
      resv_q <= resv_d;
      for (int j = 0; j <= DEPTH; j++) tag_q[j] <= tag_d[j];
    end
  end

  assign clash_o    = wr && resv_q[lat];
  assign wb_valid_o = resv_q[0];
  assign wb_dst_o   = tag_q[0];

endmodule

// File: rtl/hzd_div_gate.sv
// Occupancy of the non-pipelined divider.
module hzd_div_gate #(
  parameter int DIV_II = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy_o
);

  localparam int II_W = $clog2(DIV_II + 1);

  logic [II_W-1:0] occ_q, occ_d;

  always_comb begin
    occ_d = occ_q;
    if (start)
      occ_d = II_W'(DIV_II - 1);
    else if (occ_q != '0)
      occ_d = occ_q - II_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ_q <= '0;
    else        occ_q <= occ_d;
  end

  assign busy_o = (occ_q != '0);

endmodule

// File: rtl/hzd_issue_ctrl.sv
module hzd_issue_ctrl #(
  parameter int REG_W   = 5,
  parameter int INT_LAT = 1,
  parameter int ADD_LAT = 4,
  parameter int MUL_LAT = 7,
  parameter int DIV_LAT = 25,
  parameter int DIV_II  = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       in_unit,
  input  logic             in_wr,
  input  logic [REG_W-1:0] in_dst,
  input  logic [REG_W-1:0] in_src_a,
  input  logic             in_rd_a,
  input  logic [REG_W-1:0] in_src_b,
  input  logic             in_rd_b,
  output logic             issue_o,
  output logic             stall_o,
  output logic [3:0]       stall_why_o,
  output logic             wb_valid_o,
  output logic [REG_W-1:0] wb_dst_o
);
  import hzd_pkg::*;

  localparam int MAX_LAT = max_of4(INT_LAT, ADD_LAT, MUL_LAT, DIV_LAT);
  localparam int CNT_W   = $clog2(MAX_LAT + 1);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_s1_q, rst_s2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  unit_e            unit;
  logic [CNT_W-1:0] lat;
  logic             is_div;

  assign unit   = unit_e'(in_unit);
  assign is_div = (unit == U_DIV);

  always_comb begin
    case (unit)
      U_INT:   lat = CNT_W'(INT_LAT);
      U_ADD:   lat = CNT_W'(ADD_LAT);
      U_MUL:   lat = CNT_W'(MUL_LAT);
      default: lat = CNT_W'(DIV_LAT);
    endcase
  end

  logic raw, waw, clash, div_busy, go;
  why_t why;

  hzd_scoreboard #(.REG_W(REG_W), .CNT_W(CNT_W)) u_sb (
    .clk   (clk),
    .rst_n (rst_s2_q),
    .issue (go),
    .wr    (in_wr),
    .dst   (in_dst),
    .lat   (lat),
    .src_a (in_src_a),
    .rd_a  (in_rd_a),
    .src_b (in_src_b),
    .rd_b  (in_rd_b),
    .raw_o (raw),
    .waw_o (waw)
  );

  hzd_wb_slots #(.REG_W(REG_W), .CNT_W(CNT_W), .DEPTH(MAX_LAT)) u_wb (
    .clk        (clk),
    .rst_n      (rst_s2_q),
    .issue      (go),
    .wr         (in_wr),
    .dst        (in_dst),
    .lat        (lat),
    .clash_o    (clash),
    .wb_valid_o (wb_valid_o),
    .wb_dst_o   (wb_dst_o)
  );

  hzd_div_gate #(.DIV_II(DIV_II)) u_div (
    .clk    (clk),
    .rst_n  (rst_s2_q),
    .start  (go && is_div),
    .busy_o (div_busy)
  );

  always_comb begin
    why.div  = in_valid && is_div && div_busy;
    why.raw  = in_valid && raw;
    why.port = in_valid && clash;
    why.waw  = in_valid && waw;
  end

  assign go          = in_valid && (why == '0);
  assign issue_o     = go;
  assign stall_o     = in_valid && (why != '0);
  assign stall_why_o = why;

endmodule

// File: rtl/hzd_issue_ctrl_chk.sv
module hzd_issue_ctrl_chk #(
  parameter int REG_W  = 5,
  parameter int DIV_II = 25
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [1:0]       in_unit,
  input logic             in_wr,
  input logic [REG_W-1:0] in_dst,
  input logic [REG_W-1:0] in_src_a,
  input logic             in_rd_a,
  input logic             issue_o,
  input logic             stall_o,
  input logic [3:0]       stall_why_o,
  input logic             wb_valid_o,
  input logic [REG_W-1:0] wb_dst_o
);

  localparam int GAP_W = $clog2(DIV_II + 1) + 1;

  logic [GAP_W-1:0] gap_q;
  logic             seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (issue_o && in_unit == 2'b11) begin
      gap_q  <= GAP_W'(1);
      seen_q <= 1'b1;
    end else if (gap_q < GAP_W'(DIV_II)) begin
      gap_q  <= gap_q + GAP_W'(1);
    end
  end

  // R8
  held_is_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !issue_o |-> stall_o && !$isunknown(stall_why_o));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> !issue_o && !stall_o);

  // R1
  int_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(issue_o && in_unit == 2'b00 && in_wr) |-> wb_valid_o && wb_dst_o == $past(in_dst));

  // R2
  add_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(issue_o && in_unit == 2'b01 && in_wr) && in_valid && in_rd_a
      && in_src_a == $past(in_dst) |-> !issue_o);

  // R6
  mul_waw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(issue_o && in_unit == 2'b10 && in_wr) && in_valid && in_wr
      && in_unit == 2'b00 && in_dst == $past(in_dst) |-> stall_why_o[3]);

  // R4
  div_ii_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_o && in_unit == 2'b11 && seen_q |-> gap_q >= GAP_W'(DIV_II));

  // R9
  reset_wb_chk: assert property (@(posedge clk)
    !rst_n |-> !wb_valid_o);

endmodule

bind hzd_issue_ctrl hzd_issue_ctrl_chk #(.REG_W(REG_W), .DIV_II(DIV_II)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_unit     (in_unit),
  .in_wr       (in_wr),
  .in_dst      (in_dst),
  .in_src_a    (in_src_a),
  .in_rd_a     (in_rd_a),
  .issue_o     (issue_o),
  .stall_o     (stall_o),
  .stall_why_o (stall_why_o),
  .wb_valid_o  (wb_valid_o),
  .wb_dst_o    (wb_dst_o)
);

// File: tb/hzd_issue_ctrl_test.sv
`timescale 1ns/1ps
module hzd_issue_ctrl_test;

  localparam logic [1:0] UI = 2'b00, UA = 2'b01, UM = 2'b10, UD = 2'b11;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, in_wr, in_rd_a, in_rd_b;
  logic [1:0] in_unit;
  logic [4:0] in_dst, in_src_a, in_src_b;
  logic       issue_o, stall_o, wb_valid_o;
  logic [3:0] stall_why_o;
  logic [4:0] wb_dst_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  hzd_issue_ctrl uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_unit(in_unit),
    .in_wr(in_wr), .in_dst(in_dst), .in_src_a(in_src_a), .in_rd_a(in_rd_a),
    .in_src_b(in_src_b), .in_rd_b(in_rd_b), .issue_o(issue_o), .stall_o(stall_o),
    .stall_why_o(stall_why_o), .wb_valid_o(wb_valid_o), .wb_dst_o(wb_dst_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // offer one instruction, hold it until it issues; returns stall count and first cause
  task automatic offer(input logic [1:0] u, input logic [4:0] d, input logic w,
                       input logic [4:0] sa, input logic ra,
                       input logic [4:0] sb, input logic rb,
                       output int stalls, output logic [3:0] why1);
    stalls = 0;
    why1   = 4'b0000;
    @(negedge clk);
    in_valid = 1'b1; in_unit = u; in_dst = d; in_wr = w;
    in_src_a = sa; in_rd_a = ra; in_src_b = sb; in_rd_b = rb;
    #1;
    while (!issue_o && stalls < 300) begin
      if (stalls == 0) why1 = stall_why_o;
      // R8: a held instruction raises stall
      if (!stall_o) check(1'b0, "R8 stall_o during hold", 0, 1);
      stalls++;
      @(negedge clk);
      #1;
    end
    if (stalls >= 300) check(1'b0, "R8 instruction never issued", stalls, 0);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    check(issue_o == 1'b0, "R9 issue in reset", issue_o, 0);
    check(stall_o == 1'b0, "R9 stall in reset", stall_o, 0);
    check(wb_valid_o == 1'b0, "R9 wb in reset", wb_valid_o, 0);
  endtask

  task automatic t_after_reset();
    int s; logic [3:0] w;
    offer(UI, 5'd30, 1'b1, 5'd1, 1'b1, 5'd2, 1'b1, s, w);
    check(s == 0, "R9 no pending after reset", s, 0);
    idle(4);
  endtask

  task automatic t_int_forward();
    int s; logic [3:0] w;
    offer(UI, 5'd1, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, s, w);
    check(wb_valid_o == 1'b1, "R1 wb strobe next cycle", wb_valid_o, 1);
    check(wb_dst_o == 5'd1, "R1 wb tag", wb_dst_o, 1);
    offer(UI, 5'd2, 1'b1, 5'd1, 1'b1, 5'd0, 1'b0, s, w);
    check(s == 0, "R1 dependent int no stall", s, 0);
    idle(4);
  endtask

  task automatic t_raw_latency();
    int s; logic [3:0] w;
    offer(UA, 5'd3, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, s, w);
    offer(UI, 5'd15, 1'b1, 5'd0, 1'b0, 5'd3, 1'b1, s, w);
    check(s == 3, "R2 add consumer stalls", s, 3);
    check(w == 4'b0010, "R2 add cause bit", w, 2);
    idle(10);
    offer(UM, 5'd4, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, s, w);
    offer(UI, 5'd16, 1'b1, 5'd4, 1'b1, 5'd0, 1'b0, s, w);
    check(s == 6, "R2 mul consumer stalls", s, 6);
    idle(10);
    offer(UD, 5'd5, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, s, w);
    offer(UI, 5'd17, 1'b1, 5'd5, 1'b1, 5'd0, 1'b0, s, w);
    check(s == 24, "R2 div consumer stalls", s, 24);
    check(w == 4'b0010, "R2 div consumer cause", w, 2);
    idle(30);
  endtask

  task automatic t_src_select();
    int s; logic [3:0] w;
    offer(UM, 5'd6, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, s, w);
    // R3: source A names r6 but is not read
    offer(UI, 5'd18, 1'b1, 5'd6, 1'b0, 5'd9, 1'b1, s, w);
    check(s == 0, "R3 unread source ignored", s, 0);
    // R3: r6 on source B, offered two cycles after the multiply
    offer(UI, 5'd19, 1'b1, 5'd9, 1'b1, 5'd6, 1'b1, s, w);
    check(s == 5, "R3 source B pending", s, 5);
    idle(12);
  endtask

  task automatic t_div_interval();
    int s; logic [3:0] w;
    offer(UD, 5'd7, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, s, w);
    offer(UD, 5'd8, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, s, w);
    check(s == 24, "R4 second divide waits", s, 24);
    check(w == 4'b0001, "R4 divider busy cause", w, 1);
    idle(30);
  endtask

  task automatic t_port_clash();
    int s; logic [3:0] w;
    offer(UM, 5'd10, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, s, w);
    offer(UI, 5'd11, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, s, w);
    offer(UI, 5'd12, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, s, w);
    offer(UA, 5'd13, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, s, w);
    check(s == 1, "R5 add waits one slot", s, 1);
    check(w == 4'b0100, "R5 slot cause", w, 4);
    idle(12);
  endtask

  task automatic t_waw();
    int s; logic [3:0] w;
    offer(UM, 5'd20, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, s, w);
    offer(UI, 5'd20, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, s, w);
    check(s == 6, "R6 int behind mul", s, 6);
    check(w == 4'b1000, "R6 order cause", w, 8);
    idle(12);
    offer(UM, 5'd21, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, s, w);
    offer(UA, 5'd21, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, s, w);
    check(s == 3, "R6 add behind mul", s, 3);
    idle(12);
    offer(UI, 5'd22, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, s, w);
    offer(UM, 5'd22, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, s, w);
    check(s == 0, "R6 older finishes first", s, 0);
    idle(12);
  endtask

  task automatic t_no_write();
    int s; logic [3:0] w;
    offer(UI, 5'd23, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, s, w);
    check(wb_valid_o == 1'b0, "R7 no writeback", wb_valid_o, 0);
    idle(1);
    offer(UM, 5'd24, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, s, w);
    offer(UI, 5'd25, 1'b1, 5'd24, 1'b1, 5'd0, 1'b0, s, w);
    check(s == 0, "R7 destination not pending", s, 0);
    idle(10);
    check(issue_o == 1'b0 && stall_o == 1'b0, "R8 idle outputs", {issue_o, stall_o}, 0);
  endtask

  initial begin
    #1200000;
    check(1'b0, "watchdog expired", 0, 1);
    report();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0; in_unit = UI; in_wr = 1'b0; in_dst = '0;
    in_src_a = '0; in_rd_a = 1'b0; in_src_b = '0; in_rd_b = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_after_reset();
    t_int_forward();
    t_raw_latency();
    t_src_select();
    t_div_interval();
    t_port_clash();
    t_waw();
    t_no_write();
    report();
    $finish;
  end

endmodule